// File: doc/BRIEF.md
# Hardware Breakpoint Match Unit

This block watches a stream of instruction fetches and data accesses and flags those that fall on one of four programmed breakpoint regions. Each slot holds a trap address. A shared control word gives every slot an enable pair, an access-type code and a length code. The length code turns the address into an aligned region of 1, 2, 4 or 8 bytes.

When an access with a valid strobe matches one or more enabled slots, the unit issues one registered trap pulse. The pulse carries a vector of every slot that matched. The same slot bits are latched into a sticky status register.

Software programs and inspects the unit through a small indexed register port. A task-switch strobe clears the per-slot local enables and leaves the global enables in place.

Top module: `hwbp_unit`

## Requirements
- R1: Register indices 0 to 3 hold the trap addresses of slots 0 to 3 and read back as written. Indices 4 and 5 read as zero, and writes to them change nothing.
- R2: Index 7 is the control word. Bits 10 to 15 always read zero. Every other bit reads back as written. Slot i owns the nibble at bits 16+4i to 19+4i. Its low two bits are the access-type code and its high two bits are the length code.
- R3: The access kind is encoded as 0 for fetch, 1 for read and 2 for write. Type code 0 matches only fetches. Type code 1 matches only writes. Type code 3 matches reads and writes. Type code 2 never matches.
- R4: Length code 00 selects 1 byte, 01 selects 2 bytes, 11 selects 4 bytes and 10 selects 8 bytes. An access matches when its address equals the slot address once the low 0, 1, 2 or 3 bits are ignored.
- R5: Slot i takes part in matching only while its local enable (control bit 2i) or its global enable (control bit 2i+1) is set.
- R6: In the cycle after a valid access that matches at least one slot, `trap` is high for one cycle and `trap_slots` has exactly the matching slots set. When several slots match, they share a single pulse. Otherwise both outputs are zero.
- R7: Index 6 is the status register. Bits 0 to 3 are set by slot hits and stay set until software writes the register. A write replaces bits 0 to 3, 14 and 15, and the other bits read zero. Hits in the same cycle as a status write are ORed onto the written value.
- R8: A task-switch strobe clears every local enable bit (mask 0x55) and leaves the global enables untouched. It also wins over a control write in the same cycle.
- R9: `reg_rdata` shows, one cycle later, the register selected by `reg_idx`. The value is the one held before any write in that same cycle.
- R10: After reset, all addresses, the control word, the status register and the outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register index for the write and the read |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Registered read data |
| acc_valid | input | 1 | Access strobe |
| acc_kind | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| acc_addr | input | W | Access address |
| task_sw | input | 1 | Task-switch strobe |
| trap | output | 1 | Registered trap pulse |
| trap_slots | output | 4 | Slots that matched the access behind the pulse |

## Verification
The assertions run on every cycle and check the following:
- a pulse always names at least one slot and always follows a valid access;
- every slot named in a pulse is also present in the status register;
- the local enables are zero after a task switch;
- the reserved control and status bits read zero.

Some behaviours can only be shown by the bench's scenarios, because they depend on programmed values:
- the type-code table, including the reserved code;
- the four length regions at their edges;
- multiple matches sharing one pulse;
- read-before-write ordering;
- the precedence of a task switch over a control write and of hits over a status write.

// File: rtl/hwbp_pkg.sv
package hwbp_pkg;

  localparam int NSLOT     = 4;
  localparam int IDX_W     = 3;
  localparam int IDX_STAT  = 6;
  localparam int IDX_CTRL  = 7;
  localparam int FIELD_LSB = 16;
  localparam int FIELD_W   = 4;

  localparam logic [31:0] CTRL_KEEP = 32'hFFFF_03FF;
  localparam logic [31:0] STAT_KEEP = 32'h0000_C00F;
  localparam logic [7:0]  LOCAL_EN  = 8'h55;

  typedef enum logic [1:0] {
    KIND_FETCH = 2'd0,
    KIND_READ  = 2'd1,
    KIND_WRITE = 2'd2,
    KIND_NONE  = 2'd3
  } acc_kind_e;

  // access-type code vs access kind
  function automatic logic kind_ok(logic [1:0] code, logic [1:0] kind);
    logic r;
    case (code)
      2'd0:    r = (kind == KIND_FETCH);
      2'd1:    r = (kind == KIND_WRITE);
      2'd3:    r = (kind == KIND_READ) || (kind == KIND_WRITE);
      default: r = 1'b0;
    endcase
    return r;
  endfunction

  // low address bits ignored for a length code
  function automatic logic [2:0] len_ignore(logic [1:0] len);
    logic [2:0] m;
    case (len)
      2'b00:   m = 3'b000;
      2'b01:   m = 3'b001;
      2'b11:   m = 3'b011;
      default: m = 3'b111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/hwbp_slot_cmp.sv
module hwbp_slot_cmp
  import hwbp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] slot_addr,
  input  logic [1:0]   type_code,
  input  logic [1:0]   len_code,
  input  logic         slot_en,
  input  logic         acc_valid,
  input  logic [1:0]   acc_kind,
  input  logic [W-1:0] acc_addr,
  output logic         hit
);

  logic [W-1:0] ignore_m;
  logic         addr_eq;

  always_comb begin
    ignore_m      = '0;
    ignore_m[2:0] = len_ignore(len_code);
    addr_eq       = (((acc_addr ^ slot_addr) & ~ignore_m) == '0);
    hit           = slot_en && acc_valid && kind_ok(type_code, acc_kind) && addr_eq;
  end

endmodule

// File: rtl/hwbp_regs.sv
module hwbp_regs
  import hwbp_pkg::*;
#(
  parameter int W  = 32,
  parameter int NS = NSLOT
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [W-1:0]           wdata,
  input  logic                   task_sw,
  input  logic [NS-1:0]          hits,
  output logic [NS-1:0][W-1:0]   slot_addr,
  output logic [31:0]            ctl_q,
  output logic [31:0]            stat_q,
  output logic [W-1:0]           rdata
);

  logic [31:0] ctl_n, stat_n;
  logic [W-1:0] rd_n;

  for (genvar g = 0; g < NS; g++) begin : g_addr
    always_ff @(posedge clk) begin
      if (rst)
        slot_addr[g] <= '0;
      else if (we && idx == IDX_W'(g))
        slot_addr[g] <= wdata;
    end
  end

  always_comb begin
    ctl_n = ctl_q;
    if (we && idx == IDX_W'(IDX_CTRL))
      ctl_n = wdata[31:0] & CTRL_KEEP;
    if (task_sw)
      ctl_n[7:0] = ctl_n[7:0] & ~LOCAL_EN;

    stat_n = stat_q;
    if (we && idx == IDX_W'(IDX_STAT))
      stat_n = wdata[31:0] & STAT_KEEP;
    stat_n[NS-1:0] = stat_n[NS-1:0] | hits;

    rd_n = '0;
    for (int i = 0; i < NS; i++)
      if (idx == IDX_W'(i)) rd_n = slot_addr[i];
    if (idx == IDX_W'(IDX_STAT)) rd_n[31:0] = stat_q;
    if (idx == IDX_W'(IDX_CTRL)) rd_n[31:0] = ctl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      stat_q <= '0;
      rdata  <= '0;
    end else begin
      ctl_q  <= ctl_n;
      stat_q <= stat_n;
      rdata  <= rd_n;
    end
  end

endmodule

// File: rtl/hwbp_unit.sv
module hwbp_unit
  import hwbp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_idx,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  input  logic             acc_valid,
  input  logic [1:0]       acc_kind,
  input  logic [W-1:0]     acc_addr,
  input  logic             task_sw,
  output logic             trap,
  output logic [NSLOT-1:0] trap_slots
);

  logic [NSLOT-1:0][W-1:0] slot_addr;
  logic [31:0]             ctl_q;
  logic [31:0]             stat_q;
  logic [NSLOT-1:0]        hits;

  hwbp_regs #(.W(W), .NS(NSLOT)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .we        (reg_we),
    .idx       (reg_idx),
    .wdata     (reg_wdata),
    .task_sw   (task_sw),
    .hits      (hits),
    .slot_addr (slot_addr),
    .ctl_q     (ctl_q),
    .stat_q    (stat_q),
    .rdata     (reg_rdata)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam int FB = FIELD_LSB + FIELD_W * g;
    hwbp_slot_cmp #(.W(W)) u_cmp (
      .slot_addr (slot_addr[g]),
      .type_code (ctl_q[FB +: 2]),
      .len_code  (ctl_q[FB+2 +: 2]),
      .slot_en   (ctl_q[2*g] | ctl_q[2*g+1]),
      .acc_valid (acc_valid),
      .acc_kind  (acc_kind),
      .acc_addr  (acc_addr),
      .hit       (hits[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap       <= 1'b0;
      trap_slots <= '0;
    end else begin
      trap       <= |hits;
      trap_slots <= hits;
    end
  end

endmodule

// File: rtl/hwbp_chk.sv
module hwbp_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [2:0]   reg_idx,
  input logic [W-1:0] reg_rdata,
  input logic         acc_valid,
  input logic         task_sw,
  input logic         trap,
  input logic [3:0]   trap_slots,
  input logic [31:0]  ctl_q,
  input logic [31:0]  stat_q
);

  a_r6_pulse_names_slot: assert property (@(posedge clk) disable iff (rst)
    trap |-> (trap_slots != 4'd0));

  a_r6_pulse_after_access: assert property (@(posedge clk) disable iff (rst)
    trap |-> $past(acc_valid));

  a_r7_hits_recorded: assert property (@(posedge clk) disable iff (rst)
    trap |-> ((stat_q[3:0] & trap_slots) == trap_slots));

  a_r8_locals_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(task_sw) |-> ((ctl_q[7:0] & 8'h55) == 8'h00));

  a_r2_ctrl_reserved_read: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_idx) == 3'd7) |-> (reg_rdata[15:10] == 6'd0));

  a_r7_stat_reserved_read: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_idx) == 3'd6) |-> (reg_rdata[13:4] == 10'd0));

endmodule

bind hwbp_unit hwbp_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_idx    (reg_idx),
  .reg_rdata  (reg_rdata),
  .acc_valid  (acc_valid),
  .task_sw    (task_sw),
  .trap       (trap),
  .trap_slots (trap_slots),
  .ctl_q      (ctl_q),
  .stat_q     (stat_q)
);

// File: tb/sim_hwbp_unit.sv
module sim_hwbp_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_idx = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_kind = 2'd3;
  logic [31:0] acc_addr = '0;
  logic        task_sw = 1'b0;
  logic        trap;
  logic [3:0]  trap_slots;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hwbp_unit #(.W(32)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_kind(acc_kind), .acc_addr(acc_addr), .task_sw(task_sw),
    .trap(trap), .trap_slots(trap_slots)
  );

  // behavioural reference state
  bit [31:0] m_addr [4];
  bit [31:0] m_ctl, m_stat, m_rdata;
  bit        m_trap;
  bit [3:0]  m_slots;

  function automatic bit m_match(int s, bit [1:0] kind, bit [31:0] a);
    bit [3:0] nib = m_ctl[16+4*s +: 4];
    bit ok;
    int unsigned sz;
    case (nib[1:0])
      2'd0: ok = (kind == 2'd0);
      2'd1: ok = (kind == 2'd2);
      2'd3: ok = (kind == 2'd1) || (kind == 2'd2);
      default: ok = 1'b0;
    endcase
    case (nib[3:2])
      2'b00: sz = 1;
      2'b01: sz = 2;
      2'b11: sz = 4;
      default: sz = 8;
    endcase
    return (m_ctl[2*s] || m_ctl[2*s+1]) && ok && ((a / sz) == (m_addr[s] / sz));
  endfunction

  task automatic model_step();
    bit [3:0] h = '0;
    case (reg_idx)
      3'd6: m_rdata = m_stat;
      3'd7: m_rdata = m_ctl;
      3'd4, 3'd5: m_rdata = '0;
      default: m_rdata = m_addr[reg_idx];
    endcase
    if (acc_valid)
      for (int s = 0; s < 4; s++) h[s] = m_match(s, acc_kind, acc_addr);
    m_trap  = (h != 0);
    m_slots = h;
    if (reg_we) begin
      if (reg_idx < 3'd4) m_addr[reg_idx] = reg_wdata;
      else if (reg_idx == 3'd6) m_stat = reg_wdata & 32'h0000_C00F;
      else if (reg_idx == 3'd7) m_ctl = reg_wdata & 32'hFFFF_03FF;
    end
    if (task_sw) m_ctl = m_ctl & ~32'h55;
    m_stat[3:0] = m_stat[3:0] | h;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R6 trap", {31'd0, trap}, {31'd0, m_trap});
    chk("R6 trap_slots", {28'd0, trap_slots}, {28'd0, m_slots});
    chk("R9 rdata", reg_rdata, m_rdata);
  endtask

  task automatic wr(logic [2:0] i, logic [31:0] d);
    reg_we = 1'b1; reg_idx = i; reg_wdata = d;
    cyc();
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] i, logic [31:0] exp, string tag);
    reg_idx = i;
    cyc();
    chk(tag, reg_rdata, exp);
  endtask

  task automatic acc(logic [1:0] k, logic [31:0] a, logic [3:0] exp, string tag);
    acc_valid = 1'b1; acc_kind = k; acc_addr = a;
    cyc();
    acc_valid = 1'b0;
    chk(tag, {27'd0, trap, trap_slots}, {27'd0, exp != 0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) m_addr[s] = '0;
    m_ctl = '0; m_stat = '0; m_rdata = '0; m_trap = 0; m_slots = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    chk("R10 trap", {31'd0, trap}, 32'd0);
    rd(3'd6, 32'h0, "R10 status");
    rd(3'd7, 32'h0, "R10 control");
    rd(3'd0, 32'h0, "R10 addr0");

    // R1 address slots and unused indices
    wr(3'd0, 32'h0000_1000);
    rd(3'd0, 32'h0000_1000, "R1 addr0");
    wr(3'd4, 32'hDEAD_BEEF);
    rd(3'd4, 32'h0, "R1 idx4");
    rd(3'd5, 32'h0, "R1 idx5");

    // R2 reserved control bits
    wr(3'd7, 32'hFFFF_FFFF);
    rd(3'd7, 32'hFFFF_03FF, "R2 control");

    // slot0: write, 1 byte, local enable
    wr(3'd7, 32'h0001_0001);
    acc(2'd2, 32'h1000, 4'b0001, "R6 write hit");
    acc(2'd1, 32'h1000, 4'b0000, "R3 read vs write-only");
    acc(2'd0, 32'h1000, 4'b0000, "R3 fetch vs write-only");
    acc(2'd2, 32'h1001, 4'b0000, "R4 1-byte edge");

    // slot0 widened to 4 bytes
    wr(3'd7, 32'h000D_0001);
    acc(2'd2, 32'h1003, 4'b0001, "R4 4-byte inside");
    acc(2'd2, 32'h1004, 4'b0000, "R4 4-byte outside");

    // slot1: read/write, 8 bytes, global enable
    wr(3'd1, 32'h0000_2000);
    wr(3'd7, 32'h00BD_0009);
    acc(2'd1, 32'h2007, 4'b0010, "R3 read on rw slot");
    acc(2'd0, 32'h2000, 4'b0000, "R3 fetch on rw slot");
    acc(2'd1, 32'h2008, 4'b0000, "R4 8-byte outside");

    // R7 sticky status, write replaces
    rd(3'd6, 32'h0000_0003, "R7 sticky");
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, 32'h0000_C00F, "R7 write mask");
    wr(3'd6, 32'h0);
    rd(3'd6, 32'h0, "R7 cleared");

    // R6 two slots on one access
    wr(3'd2, 32'h0000_1000);
    wr(3'd7, 32'h01BD_0019);
    acc(2'd2, 32'h1000, 4'b0101, "R6 multi-slot");

    // R3 reserved type code 2 on slot3
    wr(3'd3, 32'h0000_3000);
    wr(3'd7, 32'h21BD_0059);
    acc(2'd2, 32'h3000, 4'b0000, "R3 reserved write");
    acc(2'd1, 32'h3000, 4'b0000, "R3 reserved read");

    // R5 enables
    wr(3'd7, 32'h11BD_0019);
    acc(2'd2, 32'h3000, 4'b0000, "R5 disabled slot");
    wr(3'd7, 32'h11BD_0099);
    acc(2'd2, 32'h3000, 4'b1000, "R5 global enable");

    // R8 task switch
    task_sw = 1'b1;
    cyc();
    task_sw = 1'b0;
    rd(3'd7, 32'h11BD_0088, "R8 locals cleared");
    acc(2'd2, 32'h1000, 4'b0000, "R8 local-only slots off");
    acc(2'd1, 32'h2000, 4'b0010, "R8 global slot kept");

    // R8 task switch beats a same-cycle control write
    task_sw = 1'b1;
    wr(3'd7, 32'h0000_000F);
    task_sw = 1'b0;
    rd(3'd7, 32'h0000_000A, "R8 precedence");

    // R9 read returns value before same-cycle write
    wr(3'd0, 32'h0000_5555);
    chk("R9 old value", reg_rdata, 32'h0000_1000);
    rd(3'd0, 32'h0000_5555, "R9 new value");

    // R7 hit merged onto a status write (slot1 now fetch type, global)
    acc_valid = 1'b1; acc_kind = 2'd0; acc_addr = 32'h2000;
    wr(3'd6, 32'h0000_4000);
    acc_valid = 1'b0;
    rd(3'd6, 32'h0000_4002, "R7 hit with write");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule